// File: doc/BRIEF.md
# Daisy-Chain Serial Command Slave for an Eight-Channel Driver

This block is the serial control front end of an eight-channel output driver. A host raises chip select (active high), toggles the serial clock and shifts command bytes in, MSB first. At the same time the block shifts out a sticky fault byte, MSB first. After that byte it returns the host's own data delayed by eight clocks, so several of these slaves can be wired in a daisy chain.

When chip select falls, the frame is checked. If the frame is valid, the last byte received becomes the channel command and the fault register is cleared. An invalid frame changes nothing.

The whole block runs on one system clock. The serial clock, chip select, data in and the two discrete enable pins are synchronised first. Edges are then found by comparing the synchronised samples. Two channels (index 4 and 5) can also be switched on by discrete pins, which are OR'd with their command bits. This lets the host drive PWM without any serial traffic.

Top module: `dchain_spi_slave`

## Requirements
- R1: `spi_do_oe` is 1 only while a frame is active. It goes to 0 after chip select falls, and it is 0 while chip select is low.
- R2: After a frame starts, the first 8 bits on `spi_do` are the fault register as it stood at the start of the frame, bit 7 first.
- R3: From bit 8 onward, `spi_do` carries the bit that was sampled from `spi_di` 8 serial-clock rising edges earlier.
- R4: `spi_do` changes only after a falling edge of the serial clock. It never changes across a rising edge.
- R5: A valid frame loads the last 8 received bits into the command register. The first of those 8 bits is command bit 7, and bit i drives `drv_en[i]`.
- R6: A frame whose bit count is zero or not a multiple of 8 leaves both the command register and the fault register unchanged.
- R7: A frame that ends while the serial clock is high is invalid and changes nothing.
- R8: A frame that starts while the serial clock is high is invalid and changes nothing.
- R9: After reset, a rise of chip select is ignored until at least one serial-clock transition has been seen. While it is ignored, `spi_do_oe` stays 0.
- R10: A high level on `disc_en[0]` drives `drv_en[4]` to 1, and a high level on `disc_en[1]` drives `drv_en[5]` to 1. When a discrete pin is low, the matching output follows its command bit.
- R11: A high level on `fault_in[i]` sets fault bit i. The bit stays set until a valid frame clears it. If the fault input is still high during the clear, the bit is set again.
- R12: Reset clears the command register and the fault register, and deasserts `spi_do_oe`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_sclk | input | 1 | Serial clock from the host |
| spi_cs | input | 1 | Chip select, active high |
| spi_di | input | 1 | Serial data in, MSB first |
| spi_do | output | 1 | Serial data out |
| spi_do_oe | output | 1 | Output enable for the serial data out pad |
| fault_in | input | 8 | Fault indications from the channels, one per channel |
| disc_en | input | 2 | Discrete enables for channels 4 and 5 |
| drv_en | output | 8 | Channel on/off outputs |

## Verification
The bench sends frames of 0, 5, 8, 12, 16 and 24 bits. Some start or end with the serial clock high. A design that validated on bit count alone would then latch a stray command or lose faults. A wrong echo tap shows up as a shifted bit stream from bit 8 on, and a pointer that moves on the rising edge breaks the check across each rising edge. A fault held high through a valid clear must come back in the next fault byte; a plain clear would lose it. A chip-select rise right after reset, before any clock edge, must leave the output disabled.

// File: rtl/dcs_pkg.sv
package dcs_pkg;
  localparam int unsigned BYTE_W   = 8;
  localparam int unsigned DISC_LO  = 4;
  localparam int unsigned DISC_N   = 2;
  localparam int unsigned SYNC_DEP = 2;
endpackage

// File: rtl/dcs_sync.sv
module dcs_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_i,
  output logic [W-1:0] sync_o
);
  logic [W-1:0] stage_q [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      logic [W-1:0] stage_n;
      if (s == 0) begin : g_first
        always_comb stage_n = async_i;
      end else begin : g_rest
        always_comb stage_n = stage_q[s-1];
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[s] <= '0;
        else        stage_q[s] <= stage_n;
      end
    end
  endgenerate

  assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/dcs_frame.sv
module dcs_frame #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sclk_s,
  input  logic         cs_s,
  input  logic         di_s,
  input  logic [W-1:0] fault_q,
  output logic         valid_end,
  output logic [W-1:0] rx_byte,
  output logic         do_bit,
  output logic         do_oe
);
  localparam int unsigned CW = (W > 1) ? $clog2(W) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(W - 1);

  logic          sclk_q, cs_q;
  logic          armed_q, armed_n;
  logic          active_q, active_n;
  logic [W-1:0]  sr_q, sr_n;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          full_q, full_n;
  logic          start_ok_q, start_ok_n;
  logic          do_q, do_n;

  logic sclk_rise, sclk_fall, cs_rise, cs_fall, frame_start;

  always_comb begin
    sclk_rise   = sclk_s & ~sclk_q;
    sclk_fall   = ~sclk_s & sclk_q;
    cs_rise     = cs_s & ~cs_q;
    cs_fall     = ~cs_s & cs_q;
    frame_start = cs_rise & armed_q;
  end

  always_comb begin
    armed_n    = armed_q | sclk_rise | sclk_fall;
    active_n   = active_q;
    sr_n       = sr_q;
    cnt_n      = cnt_q;
    full_n     = full_q;
    start_ok_n = start_ok_q;
    do_n       = do_q;
    if (frame_start) begin
      active_n   = 1'b1;
      sr_n       = fault_q;
      cnt_n      = '0;
      full_n     = 1'b0;
      start_ok_n = ~sclk_s;
      do_n       = fault_q[W-1];
    end else if (active_q) begin
      if (cs_fall) begin
        active_n = 1'b0;
        do_n     = 1'b0;
      end else begin
        if (sclk_rise) begin
          sr_n  = {sr_q[W-2:0], di_s};
          cnt_n = (cnt_q == CNT_LAST) ? '0 : cnt_q + 1'b1;
          if (cnt_q == CNT_LAST) full_n = 1'b1;
        end
        if (sclk_fall) do_n = sr_q[W-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q     <= 1'b0;
      cs_q       <= 1'b0;
      armed_q    <= 1'b0;
      active_q   <= 1'b0;
      sr_q       <= '0;
      cnt_q      <= '0;
      full_q     <= 1'b0;
      start_ok_q <= 1'b0;
      do_q       <= 1'b0;
    end else begin
      sclk_q     <= sclk_s;
      cs_q       <= cs_s;
      armed_q    <= armed_n;
      active_q   <= active_n;
      sr_q       <= sr_n;
      cnt_q      <= cnt_n;
      full_q     <= full_n;
      start_ok_q <= start_ok_n;
      do_q       <= do_n;
    end
  end

  assign valid_end = active_q & cs_fall & (cnt_q == '0) & full_q
                   & ~sclk_s & start_ok_q;
  assign rx_byte   = sr_q;
  assign do_bit    = do_q;
  assign do_oe     = active_q;

  p_oe_needs_cs_r1: assert property (@(posedge clk) disable iff (!rst_n)
    do_oe |-> cs_q);
  p_do_moves_on_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (active_q && !sclk_fall && !cs_fall) |=> $stable(do_q));
  p_start_after_arm_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(active_q) |-> armed_q);
endmodule

// File: rtl/dcs_fault.sv
module dcs_fault #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] fault_in,
  input  logic         clr,
  output logic [W-1:0] fault_q
);
  logic [W-1:0] fault_n;

  always_comb begin
    if (clr) fault_n = fault_in;
    else     fault_n = fault_q | fault_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fault_q <= '0;
    else        fault_q <= fault_n;
  end

  p_fault_sticky_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clr |=> ((fault_q & $past(fault_q)) == $past(fault_q)));
  p_fault_captured_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_in != '0) |=> ((fault_q & $past(fault_in)) == $past(fault_in)));
endmodule

// File: rtl/dcs_outs.sv
module dcs_outs #(
  parameter int unsigned W       = 8,
  parameter int unsigned DISC_LO = 4,
  parameter int unsigned DISC_N  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [W-1:0]      rx_byte,
  input  logic [DISC_N-1:0] disc_s,
  output logic [W-1:0]      drv_en
);
  logic [W-1:0] cmd_q, cmd_n;

  always_comb begin
    if (load) cmd_n = rx_byte;
    else      cmd_n = cmd_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cmd_q <= '0;
    else        cmd_q <= cmd_n;
  end

  generate
    for (genvar i = 0; i < W; i++) begin : g_ch
      if (i >= DISC_LO && i < DISC_LO + DISC_N) begin : g_disc
        assign drv_en[i] = cmd_q[i] | disc_s[i - DISC_LO];
      end else begin : g_plain
        assign drv_en[i] = cmd_q[i];
      end
    end
  endgenerate

  p_cmd_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> $stable(cmd_q));
  p_cmd_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (cmd_q == $past(rx_byte)));
endmodule

// File: rtl/dchain_spi_slave.sv
module dchain_spi_slave
  import dcs_pkg::*;
#(
  parameter int unsigned W       = BYTE_W,
  parameter int unsigned D_LO    = DISC_LO,
  parameter int unsigned D_N     = DISC_N,
  parameter int unsigned SYNC_ST = SYNC_DEP
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           spi_sclk,
  input  logic           spi_cs,
  input  logic           spi_di,
  output logic           spi_do,
  output logic           spi_do_oe,
  input  logic [W-1:0]   fault_in,
  input  logic [D_N-1:0] disc_en,
  output logic [W-1:0]   drv_en
);
  localparam int unsigned SW = 3 + D_N;

  logic [SW-1:0]  pins_s;
  logic           sclk_s, cs_s, di_s;
  logic [D_N-1:0] disc_s;
  logic [W-1:0]   fault_q, rx_byte;
  logic           valid_end;

  dcs_sync #(.W(SW), .STAGES(SYNC_ST)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i ({disc_en, spi_di, spi_cs, spi_sclk}),
    .sync_o  (pins_s)
  );

  assign sclk_s = pins_s[0];
  assign cs_s   = pins_s[1];
  assign di_s   = pins_s[2];
  assign disc_s = pins_s[SW-1:3];

  dcs_frame #(.W(W)) u_frame (
    .clk       (clk),
    .rst_n     (rst_n),
    .sclk_s    (sclk_s),
    .cs_s      (cs_s),
    .di_s      (di_s),
    .fault_q   (fault_q),
    .valid_end (valid_end),
    .rx_byte   (rx_byte),
    .do_bit    (spi_do),
    .do_oe     (spi_do_oe)
  );

  dcs_fault #(.W(W)) u_fault (
    .clk      (clk),
    .rst_n    (rst_n),
    .fault_in (fault_in),
    .clr      (valid_end),
    .fault_q  (fault_q)
  );

  dcs_outs #(.W(W), .DISC_LO(D_LO), .DISC_N(D_N)) u_outs (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (valid_end),
    .rx_byte (rx_byte),
    .disc_s  (disc_s),
    .drv_en  (drv_en)
  );

  p_reset_quiet_r12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !spi_do_oe);
endmodule

// File: tb/dchain_spi_slave_tb.sv
module dchain_spi_slave_tb_top;
  localparam int H = 6;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       spi_sclk = 1'b0, spi_cs = 1'b0, spi_di = 1'b0;
  logic       spi_do, spi_do_oe;
  logic [7:0] fault_in = '0;
  logic [1:0] disc_en = '0;
  logic [7:0] drv_en;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_fault = '0;
  logic [7:0] exp_cmd   = '0;

  always #10 clk = ~clk;

  dchain_spi_slave dut_i (
    .clk(clk), .rst_n(rst_n), .spi_sclk(spi_sclk), .spi_cs(spi_cs),
    .spi_di(spi_di), .spi_do(spi_do), .spi_do_oe(spi_do_oe),
    .fault_in(fault_in), .disc_en(disc_en), .drv_en(drv_en)
  );

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_drv(input logic [7:0] c, input logic [1:0] d);
    return c | {2'b00, d, 4'b0000};
  endfunction

  function automatic bit frame_ok(input int nb, input bit st_hi, input bit en_hi);
    return (nb > 0) && (nb % 8 == 0) && !st_hi && !en_hi;
  endfunction

  task automatic run_frame(input logic [63:0] txv, input int nb,
                           input bit st_hi, input bit en_hi, input string rq);
    logic [7:0] snap;
    logic       b, e;
    snap = exp_fault;
    spi_sclk = st_hi;
    wait_clk(H);
    spi_cs = 1'b1;
    wait_clk(H);
    chk(spi_do_oe === 1'b1, "R1", 64'(spi_do_oe), 64'd1);
    if (st_hi) begin spi_sclk = 1'b0; wait_clk(H); end
    for (int i = 0; i < nb; i++) begin
      spi_di = txv[nb-1-i];
      wait_clk(H);
      e = (i < 8) ? snap[7-i] : txv[nb-1-(i-8)];
      chk(spi_do === e, (i < 8) ? "R2" : "R3", 64'(spi_do), 64'(e));
      b = spi_do;
      spi_sclk = 1'b1;
      wait_clk(H);
      chk(spi_do === b, "R4", 64'(spi_do), 64'(b));
      if (!(en_hi && i == nb - 1)) begin spi_sclk = 1'b0; wait_clk(H); end
    end
    spi_cs = 1'b0;
    wait_clk(H);
    chk(spi_do_oe === 1'b0, "R1", 64'(spi_do_oe), 64'd0);
    if (en_hi) begin spi_sclk = 1'b0; wait_clk(H); end
    if (frame_ok(nb, st_hi, en_hi)) begin
      exp_cmd   = txv[7:0];
      exp_fault = fault_in;
    end
    wait_clk(H);
    chk(drv_en === exp_drv(exp_cmd, disc_en), rq, 64'(drv_en),
        64'(exp_drv(exp_cmd, disc_en)));
  endtask

  task automatic pulse_fault(input logic [7:0] p);
    fault_in = p;
    wait_clk(2);
    fault_in = '0;
    exp_fault |= p;
    wait_clk(2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    wait_clk(4);
    rst_n = 1'b1;
    wait_clk(4);
    // R12: reset state
    chk(spi_do_oe === 1'b0, "R12", 64'(spi_do_oe), 64'd0);
    chk(drv_en === 8'h00, "R12", 64'(drv_en), 64'd0);

    // R9: chip select before any clock transition is ignored
    spi_cs = 1'b1;
    wait_clk(3 * H);
    chk(spi_do_oe === 1'b0, "R9", 64'(spi_do_oe), 64'd0);
    spi_cs = 1'b0;
    wait_clk(H);
    spi_sclk = 1'b1; wait_clk(H);
    spi_sclk = 1'b0; wait_clk(H);

    // R12 fault byte zero, R5 load
    run_frame(64'hA5, 8, 1'b0, 1'b0, "R5");
    // R11 sticky fault, reported then cleared
    pulse_fault(8'h81);
    run_frame(64'h3C, 8, 1'b0, 1'b0, "R5");
    run_frame(64'h0F, 8, 1'b0, 1'b0, "R11");
    // R6 bad counts
    pulse_fault(8'h42);
    run_frame(64'h1F, 5, 1'b0, 1'b0, "R6");
    run_frame(64'hABC, 12, 1'b0, 1'b0, "R6");
    run_frame(64'h0, 0, 1'b0, 1'b0, "R6");
    // R7 and R8 clock level at the frame edges
    run_frame(64'hFF, 8, 1'b0, 1'b1, "R7");
    run_frame(64'hEE, 8, 1'b1, 1'b0, "R8");
    // R3 daisy chain through 24 bits
    run_frame(64'h123456, 24, 1'b0, 1'b0, "R3");
    // R11 fault held high through a valid clear
    fault_in = 8'h10;
    wait_clk(2);
    exp_fault |= 8'h10;
    run_frame(64'h00, 8, 1'b0, 1'b0, "R11");
    fault_in = '0;
    wait_clk(2);
    run_frame(64'h00, 8, 1'b0, 1'b0, "R11");
    // R10 discrete enables
    disc_en = 2'b11; wait_clk(H);
    chk(drv_en === 8'h30, "R10", 64'(drv_en), 64'h30);
    disc_en = 2'b01; wait_clk(H);
    chk(drv_en === 8'h10, "R10", 64'(drv_en), 64'h10);
    disc_en = 2'b00;
    run_frame(64'h20, 8, 1'b0, 1'b0, "R10");
    disc_en = 2'b00; wait_clk(H);
    chk(drv_en === 8'h20, "R10", 64'(drv_en), 64'h20);

    // random frames
    for (int k = 0; k < 40; k++) begin
      int sel;
      int nb;
      bit sh, eh;
      logic [63:0] tx;
      sel = int'($urandom_range(0, 5));
      case (sel)
        0: nb = 0;  1: nb = 5;  2: nb = 8;
        3: nb = 12; 4: nb = 16; default: nb = 24;
      endcase
      tx = {$urandom(), $urandom()};
      sh = ($urandom_range(0, 7) == 0);
      eh = (nb > 0) && ($urandom_range(0, 7) == 0);
      disc_en = 2'($urandom_range(0, 3));
      if ($urandom_range(0, 2) == 0) pulse_fault(8'($urandom()));
      wait_clk(H);
      run_frame(tx, nb, sh, eh, frame_ok(nb, sh, eh) ? "R5" : "R6");
    end

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule